// File: doc/BRIEF.md
# Streaming Internet Checksum Offload Engine

The engine takes one Ethernet frame at a time as a byte stream, holds the whole frame in an internal buffer, and works out a 16-bit one's-complement Internet checksum while the bytes arrive. In transmit mode, a control word and a seed word are presented with the first byte of the frame. The control word gives the byte offset where summing begins (bits 31:16) and the byte offset where the result is written (bits 15:0). The seed supplies 16 bits that join the sum. Once the last byte is in, the engine folds the sum, complements it, and replays the frame with the two checksum bytes patched in.

In receive mode, the start offset is fixed at byte 14, just past the Ethernet header. The frame is replayed unchanged. A one-cycle report gives the folded, uncomplemented partial sum and the frame length, with 4 bytes added when the frame check sequence is carried in-band. Frames in transmit mode are dropped silently when transmit is disabled. They are also dropped when their length falls in the VLAN-only window and neither jumbo nor VLAN sizing is allowed. Headers are never parsed; all offsets come from the sideband words.

Top module: `csum_offload`

## Requirements
- R1: In transmit mode the checksum is the complement of the folded sum of the seed plus the big-endian 16-bit words formed from bytes at and after the start offset. Word pairing counts from the start offset. A start offset at or past the frame end leaves only the seed.
- R2: In transmit mode the high checksum byte replaces the byte at the insertion offset and the low byte replaces the next one; every other byte leaves in its original order and value.
- R3: When the insertion offset plus one is not less than the stored frame length, the transmit frame leaves completely unchanged.
- R4: An odd trailing byte is summed as the high half of a word whose low half is zero.
- R5: In receive mode the sum starts at byte 14, is folded twice and not complemented, and the frame leaves unchanged. `rxDone` is high for exactly one cycle per frame, during the first cycle `outValid` is high, with `rxSum` and `rxLen` valid in that cycle.
- R6: `rxLen` equals the stored frame length, plus 4 when `fcsInband` was 1 at the frame's first byte.
- R7: A transmit-mode frame whose first byte arrives with `txEnable` at 0 produces no output, and `inReady` returns to 1.
- R8: With `jumboEnable` and `vlanEnable` both 0, transmit frames of 1519 to 1522 bytes are dropped. Lengths of 1518 and 1523 pass. Any of 1519 to 1522 passes when either enable is 1.
- R9: No output byte is offered before the cycle after the frame's last byte has been accepted. `inReady` and `outValid` are never high together. While `outValid` is high and `outReady` is low, `outData` and `outLast` hold.
- R10: During and right after reset, `inReady` is 1 and `outValid` and `rxDone` are 0.
- R11: Bytes beyond the buffer depth `DEPTH` are discarded: they are neither stored, summed nor replayed.
- R12: The mode, enables, control word and seed are sampled with the first byte; changes during the rest of the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxMode | input | 1 | 1 = receive sum, 0 = transmit insert (sampled on first byte) |
| txEnable | input | 1 | Transmit allowed (sampled on first byte) |
| jumboEnable | input | 1 | Lifts the frame size rule |
| vlanEnable | input | 1 | Allows 1519 to 1522 byte frames |
| fcsInband | input | 1 | Adds 4 to the reported receive length |
| ctlWord | input | 32 | Start offset in 31:16, insertion offset in 15:0 |
| ctlSeed | input | 16 | Transmit checksum seed |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Marks the final input byte |
| inReady | output | 1 | Engine accepts input |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Marks the final output byte |
| outReady | input | 1 | Sink accepts output |
| rxDone | output | 1 | One-cycle receive report strobe |
| rxSum | output | 16 | Folded receive partial sum |
| rxLen | output | 16 | Reported receive length |

## Verification
The bound checker assumes that the sink and source obey the valid/ready handshake. It also assumes that reset is held across at least one clock edge and that the buffer depth fits the length counter. The stall-hold and early-output properties depend on the source not presenting a second frame until the first has drained. The bench drives inputs only at falling edges and waits for each frame to drain or be dropped before pushing the next. It scrambles the sideband words after the first byte, so those changes never appear where sampling takes place.

// File: rtl/csum_offload_pkg.sv
package csum_offload_pkg;
  typedef enum logic [1:0] {
    CS_IDLE,
    CS_FILL,
    CS_FINAL,
    CS_SEND
  } csPhase_t;

  typedef struct packed {
    logic capture;
    logic store;
    logic finish;
    logic advance;
  } csStrobe_t;

  localparam int ETH_HDR_BYTES = 14;
  localparam int FCS_BYTES     = 4;
  localparam int STD_MAX_LEN   = 1518;
  localparam int TAG_MAX_LEN   = 1522;
endpackage

// File: rtl/csum_offload_ctrl.sv
module csum_offload_ctrl
  import csum_offload_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      outReady,
  input  logic      dropNow,
  input  logic      lastRead,
  output csStrobe_t strobe,
  output logic      inReady,
  output logic      outValid
);
  csPhase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= CS_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    unique case (phase)
      CS_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.capture = 1'b1;
          strobe.store   = 1'b1;
          phaseNext      = inLast ? CS_FINAL : CS_FILL;
        end
      end
      CS_FILL: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.store = 1'b1;
          if (inLast) phaseNext = CS_FINAL;
        end
      end
      CS_FINAL: begin
        strobe.finish = 1'b1;
        phaseNext     = dropNow ? CS_IDLE : CS_SEND;
      end
      CS_SEND: begin
        outValid = 1'b1;
        if (outReady) begin
          strobe.advance = 1'b1;
          if (lastRead) phaseNext = CS_IDLE;
        end
      end
      default: phaseNext = CS_IDLE;
    endcase
  end
endmodule

// File: rtl/csum_offload_dp.sv
module csum_offload_dp
  import csum_offload_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int LW    = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  csStrobe_t       strobe,
  input  logic [7:0]      inData,
  input  logic [31:0]     ctlWord,
  input  logic [15:0]     ctlSeed,
  input  logic            rxModeIn,
  input  logic            txEnableIn,
  input  logic            jumboIn,
  input  logic            vlanIn,
  input  logic            fcsIn,
  output logic            dropNow,
  output logic            lastRead,
  output logic [7:0]      outData,
  output logic            rxDone,
  output logic [15:0]     rxSum,
  output logic [LW-1:0]   rxLen
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    frameMem [DEPTH];
  logic [LW-1:0] fillCnt, wrIdx, rdIdx, startOff, insOff, effStart, relIdx;
  logic [15:0]   seedReg, csumReg;
  logic          modeRx, txEn, jumboOn, vlanOn, fcsOn;
  logic          roomOk, termOk, insertOk, atHigh, atLow;
  logic [31:0]   acc, term, withSeed;
  logic [16:0]   fold1;
  logic [15:0]   fold2;

  assign wrIdx  = strobe.capture ? '0 : fillCnt;
  assign roomOk = wrIdx < LW'(DEPTH);

  always_ff @(posedge clk) begin
    if (strobe.store && roomOk) frameMem[wrIdx[AW-1:0]] <= inData;
  end

  // Frame settings are sampled with the first byte only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeRx   <= 1'b0;
      txEn     <= 1'b0;
      jumboOn  <= 1'b0;
      vlanOn   <= 1'b0;
      fcsOn    <= 1'b0;
      startOff <= '0;
      insOff   <= '0;
      seedReg  <= '0;
    end else if (strobe.capture) begin
      modeRx   <= rxModeIn;
      txEn     <= txEnableIn;
      jumboOn  <= jumboIn;
      vlanOn   <= vlanIn;
      fcsOn    <= fcsIn;
      startOff <= rxModeIn ? LW'(ETH_HDR_BYTES) : ctlWord[31:16];
      insOff   <= ctlWord[15:0];
      seedReg  <= ctlSeed;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        fillCnt <= '0;
    else if (strobe.capture)          fillCnt <= LW'(1);
    else if (strobe.store && roomOk)  fillCnt <= fillCnt + LW'(1);
  end

  // Running sum: word pairing counts from the start offset
  assign effStart = strobe.capture ? (rxModeIn ? LW'(ETH_HDR_BYTES) : ctlWord[31:16])
                                   : startOff;
  assign relIdx   = wrIdx - effStart;
  assign termOk   = strobe.store && roomOk && (wrIdx >= effStart);
  assign term     = relIdx[0] ? {24'd0, inData} : {16'd0, inData, 8'd0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               acc <= '0;
    else if (strobe.capture) acc <= termOk ? term : '0;
    else if (termOk)         acc <= acc + term;
  end

  assign withSeed = acc + (modeRx ? 32'd0 : {16'd0, seedReg});
  assign fold1    = {1'b0, withSeed[31:16]} + {1'b0, withSeed[15:0]};
  assign fold2    = fold1[15:0] + {15'd0, fold1[16]};

  assign dropNow = !modeRx &&
                   (!txEn || (!jumboOn && !vlanOn &&
                              fillCnt > LW'(STD_MAX_LEN) &&
                              fillCnt <= LW'(TAG_MAX_LEN)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csumReg <= '0;
      rxDone  <= 1'b0;
      rxSum   <= '0;
      rxLen   <= '0;
    end else begin
      rxDone <= strobe.finish && modeRx;
      if (strobe.finish) begin
        csumReg <= modeRx ? fold2 : ~fold2;
        if (modeRx) begin
          rxSum <= fold2;
          rxLen <= fillCnt + (fcsOn ? LW'(FCS_BYTES) : LW'(0));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdIdx <= '0;
    else if (strobe.finish)  rdIdx <= '0;
    else if (strobe.advance) rdIdx <= rdIdx + LW'(1);
  end

  assign lastRead = rdIdx == (fillCnt - LW'(1));
  assign insertOk = !modeRx && (({1'b0, insOff} + (LW+1)'(1)) < {1'b0, fillCnt});
  assign atHigh   = rdIdx == insOff;
  assign atLow    = {1'b0, rdIdx} == ({1'b0, insOff} + (LW+1)'(1));

  always_comb begin
    if (insertOk && atHigh)     outData = csumReg[15:8];
    else if (insertOk && atLow) outData = csumReg[7:0];
    else                        outData = frameMem[rdIdx[AW-1:0]];
  end
endmodule

// File: rtl/csum_offload.sv
module csum_offload
  import csum_offload_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int LW    = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxMode,
  input  logic          txEnable,
  input  logic          jumboEnable,
  input  logic          vlanEnable,
  input  logic          fcsInband,
  input  logic [31:0]   ctlWord,
  input  logic [15:0]   ctlSeed,
  input  logic          inValid,
  input  logic [7:0]    inData,
  input  logic          inLast,
  output logic          inReady,
  output logic          outValid,
  output logic [7:0]    outData,
  output logic          outLast,
  input  logic          outReady,
  output logic          rxDone,
  output logic [15:0]   rxSum,
  output logic [LW-1:0] rxLen
);
  csStrobe_t strobe;
  logic      dropNow, lastRead;

  csum_offload_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .dropNow  (dropNow),
    .lastRead (lastRead),
    .strobe   (strobe),
    .inReady  (inReady),
    .outValid (outValid)
  );

  csum_offload_dp #(.DEPTH(DEPTH), .LW(LW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .ctlWord    (ctlWord),
    .ctlSeed    (ctlSeed),
    .rxModeIn   (rxMode),
    .txEnableIn (txEnable),
    .jumboIn    (jumboEnable),
    .vlanIn     (vlanEnable),
    .fcsIn      (fcsInband),
    .dropNow    (dropNow),
    .lastRead   (lastRead),
    .outData    (outData),
    .rxDone     (rxDone),
    .rxSum      (rxSum),
    .rxLen      (rxLen)
  );

  assign outLast = outValid && lastRead;
endmodule

// File: rtl/csum_offload_checker.sv
module csum_offload_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inLast,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       outReady,
  input logic       rxDone
);
  assert_reset_idle_R10: assert property (@(posedge clk)
    !rstN |=> (inReady && !outValid && !rxDone));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_last_in_beat_R9: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  assert_no_early_out_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !outValid);

  assert_single_report_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  assert_report_with_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> outValid);
endmodule

bind csum_offload csum_offload_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inLast   (inLast),
  .inReady  (inReady),
  .outValid (outValid),
  .outData  (outData),
  .outLast  (outLast),
  .outReady (outReady),
  .rxDone   (rxDone)
);

// File: tb/csum_offload_test.sv
`timescale 1ns/1ps
module csum_offload_test;
  localparam int DEPTH = 2048;
  localparam int BUFN  = 2100;

  typedef struct packed {
    logic        rx;
    logic        fcs;
    logic [15:0] len;
    logic [15:0] st;
    logic [15:0] ins;
    logic [15:0] seed;
    logic [7:0]  mul;
    logic [7:0]  add;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'd60,  16'd14, 16'd24,  16'h1234, 8'd3,   8'd1},
    '{1'b0, 1'b0, 16'd61,  16'd14, 16'd40,  16'h0000, 8'd7,   8'h55},
    '{1'b0, 1'b0, 16'd20,  16'd0,  16'd19,  16'hFFFF, 8'd11,  8'd2},
    '{1'b0, 1'b0, 16'd33,  16'd33, 16'd2,   16'hABCD, 8'd5,   8'd9},
    '{1'b1, 1'b0, 16'd64,  16'd0,  16'd3,   16'h7777, 8'd5,   8'd9},
    '{1'b1, 1'b1, 16'd71,  16'd0,  16'd3,   16'h0101, 8'd13,  8'd200},
    '{1'b0, 1'b0, 16'd100, 16'd34, 16'd50,  16'hFFFF, 8'hFF,  8'hFF},
    '{1'b1, 1'b1, 16'd14,  16'd0,  16'd3,   16'h0000, 8'd1,   8'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxMode = 1'b0, txEnable = 1'b1, jumboEnable = 1'b0, vlanEnable = 1'b0, fcsInband = 1'b0;
  logic [31:0] ctlWord = '0;
  logic [15:0] ctlSeed = '0;
  logic inValid = 1'b0, inLast = 1'b0, outReady = 1'b1;
  logic [7:0] inData = '0;
  logic inReady, outValid, outLast, rxDone;
  logic [7:0] outData;
  logic [15:0] rxSum, rxLen;

  always #4 clk = ~clk;

  csum_offload #(.DEPTH(DEPTH), .LW(16)) uut (
    .clk(clk), .rstN(rstN), .rxMode(rxMode), .txEnable(txEnable),
    .jumboEnable(jumboEnable), .vlanEnable(vlanEnable), .fcsInband(fcsInband),
    .ctlWord(ctlWord), .ctlSeed(ctlSeed), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inReady(inReady), .outValid(outValid), .outData(outData),
    .outLast(outLast), .outReady(outReady), .rxDone(rxDone), .rxSum(rxSum),
    .rxLen(rxLen)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] inBuf  [BUFN];
  logic [7:0] outBuf [BUFN];
  logic [7:0] expBuf [BUFN];
  int rxSeen = 0;
  logic [15:0] rxSumSeen, rxLenSeen;

  always @(negedge clk) begin
    if (rstN && rxDone) begin
      rxSeen++;
      rxSumSeen = rxSum;
      rxLenSeen = rxLen;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8ns * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  function automatic logic [15:0] model(int len, int st, logic [15:0] seed, bit tx);
    logic [31:0] s = 0;
    for (int i = st; i < len; i++)
      s += (((i - st) % 2) == 0) ? {16'd0, inBuf[i], 8'd0} : {24'd0, inBuf[i]};
    if (tx) s += {16'd0, seed};
    s = {16'd0, s[31:16]} + {16'd0, s[15:0]};
    s = {16'd0, s[31:16]} + {16'd0, s[15:0]};
    return tx ? ~s[15:0] : s[15:0];
  endfunction

  task automatic fillBuf(int len, logic [7:0] mul, logic [7:0] add);
    for (int i = 0; i < len && i < BUFN; i++) inBuf[i] = 8'(i * mul + add);
  endtask

  // Sideband is scrambled after the first byte (R12)
  task automatic pushFrame(int len, bit rx, logic [15:0] st, logic [15:0] ins,
                           logic [15:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = inBuf[i];
      inLast  = (i == len - 1);
      if (i == 0) begin
        rxMode = rx; ctlWord = {st, ins}; ctlSeed = seed;
      end else begin
        rxMode = ~rx; ctlWord = ~{st, ins}; ctlSeed = ~seed;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    check(!outValid, "R9", "output before finalize", outValid, 0);
  endtask

  task automatic collect(output int n, input bit stall);
    int cyc = 0;
    bit done = 0;
    n = 0;
    while (!done && cyc < 6000) begin
      cyc++;
      outReady = stall ? ((cyc % 3) != 0) : 1'b1;
      if (outValid && outReady) begin
        if (n < BUFN) outBuf[n] = outData;
        n++;
        if (outLast) done = 1;
      end
      @(negedge clk);
    end
    outReady = 1'b1;
  endtask

  task automatic runFrame(bit rx, bit fcs, int len, int st, int ins,
                          logic [15:0] seed, bit stall, bit expDrop, string req);
    int n, stored, bad, rxBefore;
    logic [15:0] c;
    fcsInband = fcs;
    rxBefore  = rxSeen;
    stored    = (len > DEPTH) ? DEPTH : len;
    pushFrame(len, rx, 16'(st), 16'(ins), seed);
    if (expDrop) begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (outValid) seen++;
      end
      check(seen == 0, req, "dropped frame produced output", seen, 0);
      check(inReady, req, "inReady after drop", inReady, 1);
      return;
    end
    c = model(stored, rx ? 14 : st, seed, !rx);
    for (int i = 0; i < stored; i++) expBuf[i] = inBuf[i];
    if (!rx && (ins + 1 < stored)) begin
      expBuf[ins]     = c[15:8];
      expBuf[ins + 1] = c[7:0];
    end
    @(negedge clk);
    collect(n, stall);
    check(n == stored, req, "output length", n, stored);
    bad = 0;
    for (int i = 0; i < stored && i < n; i++) if (outBuf[i] !== expBuf[i]) bad++;
    check(bad == 0, req, "mismatching output bytes (R1 R2 R12)", bad, 0);
    if (rx) begin
      check(rxSeen == rxBefore + 1, "R5", "report count", rxSeen - rxBefore, 1);
      check(rxSumSeen == c, "R5", "receive sum", rxSumSeen, c);
      check(rxLenSeen == 16'(stored + (fcs ? 4 : 0)), "R6", "receive length",
            rxLenSeen, stored + (fcs ? 4 : 0));
    end else begin
      check(rxSeen == rxBefore, "R5", "no report in transmit", rxSeen - rxBefore, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < BUFN; i++) begin inBuf[i] = '0; outBuf[i] = '0; expBuf[i] = '0; end
    repeat (3) @(negedge clk);
    check(inReady, "R10", "inReady in reset", inReady, 1);
    check(!outValid && !rxDone, "R10", "outputs idle in reset", outValid + rxDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady && !outValid, "R10", "idle after reset", inReady, 1);

    for (int v = 0; v < NV; v++) begin
      fillBuf(VECS[v].len, VECS[v].mul, VECS[v].add);
      runFrame(VECS[v].rx, VECS[v].fcs, VECS[v].len, VECS[v].st, VECS[v].ins,
               VECS[v].seed, v[0], 1'b0,
               VECS[v].rx ? "R5" : ((VECS[v].len[0]) ? "R4" : "R1"));
    end

    // R7: transmit disabled
    fillBuf(60, 8'd3, 8'd4);
    txEnable = 1'b0;
    runFrame(1'b0, 1'b0, 60, 14, 20, 16'h0, 1'b0, 1'b1, "R7");
    txEnable = 1'b1;
    runFrame(1'b0, 1'b0, 60, 14, 20, 16'h0, 1'b0, 1'b0, "R7");

    // R8: size window
    fillBuf(1530, 8'd1, 8'd0);
    runFrame(1'b0, 1'b0, 1518, 14, 20, 16'h5, 1'b0, 1'b0, "R8");
    runFrame(1'b0, 1'b0, 1519, 14, 20, 16'h5, 1'b0, 1'b1, "R8");
    runFrame(1'b0, 1'b0, 1522, 14, 20, 16'h5, 1'b0, 1'b1, "R8");
    runFrame(1'b0, 1'b0, 1523, 14, 20, 16'h5, 1'b0, 1'b0, "R8");
    vlanEnable = 1'b1;
    runFrame(1'b0, 1'b0, 1520, 14, 20, 16'h5, 1'b0, 1'b0, "R8");
    vlanEnable = 1'b0;
    jumboEnable = 1'b1;
    runFrame(1'b0, 1'b0, 1521, 14, 20, 16'h5, 1'b1, 1'b0, "R8");

    // R11: overflow beyond depth
    fillBuf(DEPTH + 2, 8'd7, 8'd3);
    runFrame(1'b0, 1'b0, DEPTH + 2, 14, 5000, 16'h9, 1'b0, 1'b0, "R11");
    jumboEnable = 1'b0;

    // R3: insertion just out of range after overflow-free frame
    fillBuf(10, 8'd9, 8'd1);
    runFrame(1'b0, 1'b0, 10, 0, 9, 16'h1, 1'b1, 1'b0, "R3");

    finishRun();
  end
endmodule